// File: doc/BRIEF.md
# Handshaked Pipeline Stage Controller

This block controls one stage of a pipeline in which each step is ordered by request and acknowledge signals rather than by a fixed schedule. On the upstream side it takes a request, returns an acknowledge, and captures an operand. Toward a local compute unit it issues a start pulse with that operand and waits for a done indication, which may come after any number of cycles. It then holds the result and offers it downstream with a request, and becomes free again only after the next stage has acknowledged the result.

Both edges use a four-phase protocol. A request stays high until its acknowledge is seen and then falls. The acknowledge then falls, and only after that can the next transfer begin. Stages can be chained by wiring one stage's downstream side to the next stage's upstream side. Internally the stage moves through four states: idle, computing, offering and releasing.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the stage is idle and `up_ack`, `cu_start` and `dn_req` are all low.
- R2: A request is accepted only when the stage is idle and `up_ack` is low. On acceptance, `up_data` is captured and `up_ack` rises in the next cycle. A request raised while the stage is computing, offering or releasing gets no acknowledge until the stage is idle again.
- R3: `up_ack` stays high for as long as `up_req` is high. It falls in the cycle after `up_req` is sampled low.
- R4: `cu_start` is high for exactly one cycle per accepted request, in the same cycle in which `up_ack` rises.
- R5: `cu_operand` equals the captured `up_data` from the start pulse onward. It stays stable until the next acceptance, even if `up_data` changes.
- R6: A `cu_done` that arrives while the stage is not computing is ignored. Neither `dn_req` nor `dn_data` changes.
- R7: `dn_req` does not rise before `cu_done` has been seen during computation. It rises in the cycle after that, and `dn_data` then holds the `cu_result` sampled with `cu_done`.
- R8: While `dn_req` is high and `dn_ack` is low, `dn_req` and `dn_data` stay unchanged. `dn_req` falls in the cycle after `dn_ack` is sampled high.
- R9: After an offer is acknowledged, the stage accepts no new request until `dn_ack` has been sampled low. An acceptance can happen at the earliest one cycle after that.
- R10: Two chained stages with varying compute latencies and downstream acknowledge delays deliver every item exactly once, in order, with both stage functions applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Request from the upstream side |
| up_ack | output | 1 | Acknowledge to the upstream side |
| up_data | input | DATA_W | Operand offered by the upstream side |
| cu_start | output | 1 | One-cycle start pulse to the compute unit |
| cu_operand | output | DATA_W | Captured operand for the compute unit |
| cu_done | input | 1 | Compute unit reports a stable result |
| cu_result | input | RES_W | Result from the compute unit |
| dn_req | output | 1 | Request to the downstream stage |
| dn_ack | input | 1 | Acknowledge from the downstream stage |
| dn_data | output | RES_W | Result offered downstream |

## Verification
Several protocol rules are checked by the assertions on every cycle:
- the reset values,
- the acknowledge that rises only on a request and falls only after the request has dropped,
- the single-cycle start pulse,
- the stable operand after start,
- the downstream request that appears only after done,
- the held offer while the acknowledge is pending,
- the absence of any acceptance while an offer is outstanding.

Other behaviours need a chosen sequence of stimuli and can only be shown by the bench's scenarios:
- that stray done pulses are ignored,
- that a request raised mid-computation waits until the release phase ends,
- that a chain of two stages delivers an ordered, lossless and duplicate-free stream under varied latencies.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPUTE = 2'd1,
        ST_OFFER   = 2'd2,
        ST_RELEASE = 2'd3
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      start;
    } ctrl_regs_t;

endpackage

// File: rtl/hs_rx.sv
// Upstream receive side: captures the operand and runs the four-phase acknowledge.
module hs_rx #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic [DATA_W-1:0] up_data,
    input  logic              accept,
    output logic              up_ack,
    output logic [DATA_W-1:0] operand
);

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] data;
    } rx_regs_t;

    rx_regs_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (accept) begin
            rx_d.ack  = 1'b1;
            rx_d.data = up_data;
        end else if (!up_req) begin
            rx_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign up_ack  = rx_q.ack;
    assign operand = rx_q.data;

endmodule

// File: rtl/hs_tx.sv
// Downstream offer side: holds the result and runs the four-phase request.
module hs_tx #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] result,
    input  logic             drop,
    output logic             dn_req,
    output logic [RES_W-1:0] dn_data
);

    typedef struct packed {
        logic             req;
        logic [RES_W-1:0] data;
    } tx_regs_t;

    tx_regs_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load) begin
            tx_d.req  = 1'b1;
            tx_d.data = result;
        end else if (drop) begin
            tx_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign dn_req  = tx_q.req;
    assign dn_data = tx_q.data;

endmodule

// File: rtl/hs_ctrl.sv
// Sequencer: orders acceptance, start, completion, offer and release.
module hs_ctrl
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_req,
    input  logic      up_ack,
    input  logic      cu_done,
    input  logic      dn_ack,
    output logic      accept,
    output logic      take,
    output logic      drop,
    output logic      cu_start,
    output hs_state_e state
);

    ctrl_regs_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        accept    = 1'b0;
        take      = 1'b0;
        drop      = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (up_req && !up_ack) begin
                    accept    = 1'b1;
                    c_d.start = 1'b1;
                    c_d.st    = ST_COMPUTE;
                end
            end
            ST_COMPUTE: begin
                if (cu_done) begin
                    take   = 1'b1;
                    c_d.st = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (dn_ack) begin
                    drop   = 1'b1;
                    c_d.st = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (!dn_ack) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, start: 1'b0};
        else        c_q <= c_d;
    end

    assign cu_start = c_q.start;
    assign state    = c_q.st;

endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
    import hs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    output logic              up_ack,
    input  logic [DATA_W-1:0] up_data,
    output logic              cu_start,
    output logic [DATA_W-1:0] cu_operand,
    input  logic              cu_done,
    input  logic [RES_W-1:0]  cu_result,
    output logic              dn_req,
    input  logic              dn_ack,
    output logic [RES_W-1:0]  dn_data
);

    logic      accept_w;
    logic      take_w;
    logic      drop_w;
    hs_state_e state_w;

    hs_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_req   (up_req),
        .up_ack   (up_ack),
        .cu_done  (cu_done),
        .dn_ack   (dn_ack),
        .accept   (accept_w),
        .take     (take_w),
        .drop     (drop_w),
        .cu_start (cu_start),
        .state    (state_w)
    );

    hs_rx #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_req  (up_req),
        .up_data (up_data),
        .accept  (accept_w),
        .up_ack  (up_ack),
        .operand (cu_operand)
    );

    hs_tx #(.RES_W(RES_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_w),
        .result  (cu_result),
        .drop    (drop_w),
        .dn_req  (dn_req),
        .dn_data (dn_data)
    );

endmodule

// File: rtl/hs_stage_chk.sv
module hs_stage_chk #(
    parameter int DATA_W = 16,
    parameter int RES_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req,
    input logic              up_ack,
    input logic              cu_start,
    input logic [DATA_W-1:0] cu_operand,
    input logic              cu_done,
    input logic              dn_req,
    input logic              dn_ack,
    input logic [RES_W-1:0]  dn_data
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!up_ack && !cu_start && !dn_req));

    assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_ack) |-> $past(up_req));

    assert_ack_falls_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_ack) |-> $past(!up_req));

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cu_start |=> !cu_start);

    assert_start_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cu_start |-> $rose(up_ack));

    assert_operand_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cu_start |=> $stable(cu_operand));

    assert_offer_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_req) |-> $past(cu_done));

    assert_offer_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_data)));

    assert_offer_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ack) |=> !dn_req);

    assert_no_accept_while_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dn_req) |-> !$rose(up_ack));

endmodule

bind hs_stage_ctrl hs_stage_chk #(.DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_req     (up_req),
    .up_ack     (up_ack),
    .cu_start   (cu_start),
    .cu_operand (cu_operand),
    .cu_done    (cu_done),
    .dn_req     (dn_req),
    .dn_ack     (dn_ack),
    .dn_data    (dn_data)
);

// File: tb/sim_hs_stage_ctrl.sv
`timescale 1ns/1ps
module sim_hs_stage_ctrl;

    localparam int W = 16;
    localparam int N_CHAIN = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // single stage under directed control
    logic         u_req = 1'b0, c_done = 1'b0, d_ack = 1'b0;
    logic [W-1:0] u_data = '0, c_res = '0;
    logic         u_ack, c_start, d_req;
    logic [W-1:0] c_op, d_data;

    hs_stage_ctrl #(.DATA_W(W), .RES_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .up_req(u_req), .up_ack(u_ack), .up_data(u_data),
        .cu_start(c_start), .cu_operand(c_op), .cu_done(c_done), .cu_result(c_res),
        .dn_req(d_req), .dn_ack(d_ack), .dn_data(d_data)
    );

    // two chained stages
    logic         a_req = 1'b0, a_done = 1'b0, b_done = 1'b0, b_ack = 1'b0;
    logic [W-1:0] a_in = '0, a_res = '0, b_res = '0;
    logic         a_ack, a_start, ab_req, ab_ack, b_start, b_req;
    logic [W-1:0] a_op, ab_data, b_op, b_out;

    hs_stage_ctrl #(.DATA_W(W), .RES_W(W)) u_a (
        .clk(clk), .rst_n(rst_n),
        .up_req(a_req), .up_ack(a_ack), .up_data(a_in),
        .cu_start(a_start), .cu_operand(a_op), .cu_done(a_done), .cu_result(a_res),
        .dn_req(ab_req), .dn_ack(ab_ack), .dn_data(ab_data)
    );

    hs_stage_ctrl #(.DATA_W(W), .RES_W(W)) u_b (
        .clk(clk), .rst_n(rst_n),
        .up_req(ab_req), .up_ack(ab_ack), .up_data(ab_data),
        .cu_start(b_start), .cu_operand(b_op), .cu_done(b_done), .cu_result(b_res),
        .dn_req(b_req), .dn_ack(b_ack), .dn_data(b_out)
    );

    logic [W-1:0] exp_q[$];
    int n_rcv = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // compute unit of stage a: result = operand + 3
    initial forever begin
        @(negedge clk);
        if (a_start) begin
            logic [W-1:0] opa;
            opa = a_op;
            repeat ($urandom_range(0, 5)) @(negedge clk);
            a_res = opa + 16'd3;
            a_done = 1'b1;
            @(negedge clk);
            a_done = 1'b0;
            a_res = 16'hdead;
        end
    end

    // compute unit of stage b: result = operand ^ 5a5a
    initial forever begin
        @(negedge clk);
        if (b_start) begin
            logic [W-1:0] opb;
            opb = b_op;
            repeat ($urandom_range(0, 6)) @(negedge clk);
            b_res = opb ^ 16'h5a5a;
            b_done = 1'b1;
            @(negedge clk);
            b_done = 1'b0;
            b_res = 16'hbeef;
        end
    end

    // downstream consumer of the chain
    initial forever begin
        @(negedge clk);
        if (b_req && !b_ack) begin
            repeat ($urandom_range(0, 4)) @(negedge clk);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 duplicate", b_out, 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(b_out == e, "R10 order/value", b_out, e);
            end
            n_rcv++;
            b_ack = 1'b1;
            while (b_req) @(negedge clk);
            b_ack = 1'b0;
        end
    end

    task automatic t_reset();
        @(negedge clk);
        chk(!u_ack, "R1 up_ack", u_ack, 0);
        chk(!c_start, "R1 cu_start", c_start, 0);
        chk(!d_req, "R1 dn_req", d_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!u_ack && !c_start && !d_req, "R1 after release", {u_ack, c_start, d_req}, 0);
    endtask

    task automatic t_basic(input logic [W-1:0] din, input logic [W-1:0] res, input int lat, input int ackdly);
        u_data = din; u_req = 1'b1;
        @(negedge clk);
        chk(u_ack, "R2 ack", u_ack, 1);
        chk(c_start, "R4 start", c_start, 1);
        chk(c_op == din, "R5 operand", c_op, din);
        u_req = 1'b0; u_data = ~din;
        @(negedge clk);
        chk(!c_start, "R4 pulse width", c_start, 0);
        chk(!u_ack, "R3 ack falls", u_ack, 0);
        chk(c_op == din, "R5 operand hold", c_op, din);
        for (int i = 0; i < lat; i++) begin
            chk(!d_req, "R7 no early offer", d_req, 0);
            @(negedge clk);
        end
        c_done = 1'b1; c_res = res;
        @(negedge clk);
        chk(d_req, "R7 offer", d_req, 1);
        chk(d_data == res, "R7 result", d_data, res);
        c_done = 1'b0; c_res = ~res;
        for (int i = 0; i < ackdly; i++) begin
            @(negedge clk);
            chk(d_req && d_data == res, "R8 hold", {d_req, d_data}, {1'b1, res});
        end
        d_ack = 1'b1;
        @(negedge clk);
        chk(!d_req, "R8 drop", d_req, 0);
        d_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_ack_hold();
        u_data = 16'h0c0c; u_req = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(u_ack, "R3 ack held", u_ack, 1);
            @(negedge clk);
        end
        u_req = 1'b0;
        @(negedge clk);
        chk(!u_ack, "R3 ack release", u_ack, 0);
        c_done = 1'b1; c_res = 16'h1111;
        @(negedge clk);
        c_done = 1'b0;
        d_ack = 1'b1;
        @(negedge clk);
        d_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_busy();
        u_data = 16'h2222; u_req = 1'b1;
        @(negedge clk);
        u_req = 1'b0;
        @(negedge clk);
        u_data = 16'h3333; u_req = 1'b1;   // new request while computing
        repeat (3) begin
            @(negedge clk);
            chk(!u_ack, "R2 busy compute", u_ack, 0);
        end
        c_done = 1'b1; c_res = 16'h4444;
        @(negedge clk);
        c_done = 1'b0;
        chk(!u_ack, "R2 busy offer", u_ack, 0);
        chk(c_op == 16'h2222, "R5 operand busy", c_op, 16'h2222);
        d_ack = 1'b1;
        @(negedge clk);
        d_ack = 1'b0;
        @(negedge clk);                       // release -> idle
        chk(!u_ack, "R9 still releasing", u_ack, 0);
        @(negedge clk);
        chk(u_ack && c_op == 16'h3333, "R2 late accept", c_op, 16'h3333);
        u_req = 1'b0;
        @(negedge clk);
        c_done = 1'b1; c_res = 16'h5555;
        @(negedge clk);
        c_done = 1'b0;
        d_ack = 1'b1;
        @(negedge clk);
        d_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_release();
        u_data = 16'h6666; u_req = 1'b1;
        @(negedge clk);
        u_req = 1'b0;
        @(negedge clk);
        c_done = 1'b1; c_res = 16'h7777;
        @(negedge clk);
        c_done = 1'b0;
        d_ack = 1'b1;
        u_data = 16'h8888; u_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!u_ack, "R9 ack still high", u_ack, 0);
        end
        d_ack = 1'b0;
        @(negedge clk);
        chk(!u_ack, "R9 release cycle", u_ack, 0);
        @(negedge clk);
        chk(u_ack && c_op == 16'h8888, "R9 accept after release", c_op, 16'h8888);
        u_req = 1'b0;
        @(negedge clk);
        c_done = 1'b1; c_res = 16'h9999;
        @(negedge clk);
        c_done = 1'b0;
        d_ack = 1'b1;
        @(negedge clk);
        d_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_stray_done();
        c_done = 1'b1; c_res = 16'haaaa;     // done while idle
        repeat (2) @(negedge clk);
        c_done = 1'b0;
        chk(!d_req, "R6 idle done", d_req, 0);
        u_data = 16'h0101; u_req = 1'b1;
        @(negedge clk);
        u_req = 1'b0;
        @(negedge clk);
        chk(!d_req, "R6 no offer from stray", d_req, 0);
        c_done = 1'b1; c_res = 16'h0202;
        @(negedge clk);
        c_res = 16'hbbbb;                     // done kept high into offer
        @(negedge clk);
        chk(d_req && d_data == 16'h0202, "R6 offer done ignored", d_data, 16'h0202);
        c_done = 1'b0;
        d_ack = 1'b1;
        @(negedge clk);
        d_ack = 1'b0;
        c_done = 1'b1; c_res = 16'hcccc;     // done while releasing
        @(negedge clk);
        c_done = 1'b0;
        @(negedge clk);
        chk(!d_req && d_data == 16'h0202, "R6 release done ignored", d_data, 16'h0202);
    endtask

    task automatic t_chain();
        for (int i = 0; i < N_CHAIN; i++) begin
            logic [W-1:0] v;
            v = 16'h1000 + W'(i * 37);
            @(negedge clk);
            a_in = v; a_req = 1'b1;
            while (!a_ack) @(negedge clk);
            exp_q.push_back((v + 16'd3) ^ 16'h5a5a);
            a_req = 1'b0;
            while (a_ack) @(negedge clk);
        end
        for (int i = 0; i < 2000 && n_rcv < N_CHAIN; i++) @(negedge clk);
        chk(n_rcv == N_CHAIN, "R10 count", n_rcv, N_CHAIN);
        chk(exp_q.size() == 0, "R10 lossless", exp_q.size(), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_basic(16'h1234, 16'habcd, 0, 0);
        t_basic(16'h00ff, 16'hf00f, 5, 3);
        t_basic(16'hffff, 16'h0000, 2, 7);
        t_ack_hold();
        t_busy();
        t_release();
        t_stray_done();
        t_chain();
        summary();
    end

endmodule